// File: doc/BRIEF.md
# Three-Stage Forwarding Register-File Datapath

This block is the execute core of a small in-order pipeline. Each cycle it accepts one register-to-register instruction: a two-bit opcode, two source register numbers, a destination register number and a stall flag. The instruction moves through three overlapping stages. The operand-read stage captures both sources. The compute stage registers the ALU result. The write stage stores that result into the register file at the destination register.

Results that are still in flight reach younger instructions over two forwarding paths. One carries the live ALU output of the instruction in the compute stage. The other carries the write-back register of the instruction in the write stage. A stall flag aborts the instruction being read. The flag travels down the pipeline with the instruction, so an aborted instruction neither forwards its result nor writes it back.

A combinational debug read port exposes any register, which lets the surrounding environment observe architectural state.

Top module: `pipe3_core`

## Requirements
- R1: While reset is asserted, and again when it is released, register i holds the value i and both carried stall flags read as set. Stalled instructions issued after release leave every register unchanged.
- R2: The opcode selects the ALU function: 0 adds, 1 subtracts the second source from the first (modulo 2^DW), 2 is bitwise AND, 3 is bitwise XOR.
- R3: An unstalled instruction presented in cycle t has its result in its destination register, readable on the debug port, in cycle t+3. That result is the function of its sources with the results of all older instructions applied.
- R4: When a source matches the destination of the unstalled instruction one cycle older, the operand is taken from the live ALU output.
- R5: When a source matches the destination of the unstalled instruction two cycles older, and not the one cycle older, the operand is taken from the write-back register.
- R6: When a source matches both older unstalled destinations, the one-cycle-older result wins.
- R7: An instruction presented with stall high writes no register.
- R8: A stalled instruction still in flight forwards nothing, so a younger reader of its destination gets the older value.
- R9: The debug port returns the addressed register in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_op | input | 2 | ALU function select |
| in_src_a | input | AW | First source register |
| in_src_b | input | AW | Second source register |
| in_dst | input | AW | Destination register |
| in_stall | input | 1 | Abort the instruction presented this cycle |
| dbg_addr | input | AW | Debug read register number |
| dbg_data | output | DW | Debug read data |

## Verification
An instruction presented in cycle t is captured at the edge that closes t. Its ALU result is registered at the end of t+1 and written at the end of t+2, so the debug port shows it during t+3 and no earlier. On every cycle the bench drives the next instruction at the falling edge. It then points the debug port at the destination of the instruction issued three cycles before and samples one time unit later. The expected value is the one an in-order reference model recorded when that instruction was issued. Reset values and the final contents of every register are read the same way, away from the rising edge.

// File: rtl/pipe3_pkg.sv
package pipe3_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_AND = 2'd2,
    OP_XOR = 2'd3
  } alu_op_e;

  localparam int unsigned NUM_OPND = 2;
endpackage

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = 8,
  parameter int unsigned NRD  = 2,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [DW-1:0]           wr_data,
  input  logic [NRD-1:0][AW-1:0]  rd_addr,
  output logic [NRD-1:0][DW-1:0]  rd_data,
  input  logic [AW-1:0]           dbg_addr,
  output logic [DW-1:0]           dbg_data
);
  logic [DW-1:0] mem_q [NREG];

  // One write per cycle; each word has its own enable and resets to its index.
  for (genvar g = 0; g < NREG; g++) begin : g_word
    logic          word_en;
    logic [DW-1:0] word_nxt;

    always_comb begin
      word_en  = wr_en && (wr_addr == AW'(g));
      word_nxt = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= DW'(g);
      end else if (word_en) begin
        mem_q[g] <= word_nxt;
      end
    end
  end

  // Reads return the stored contents (old value during a same-cycle write).
  for (genvar r = 0; r < NRD; r++) begin : g_rd
    always_comb rd_data[r] = mem_q[rd_addr[r]];
  end

  always_comb dbg_data = mem_q[dbg_addr];

  // R3: a write is observable on the debug port in the next cycle
  p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en ##1 (dbg_addr == $past(wr_addr)) |-> dbg_data == $past(wr_data));

  // R7: without a write the addressed word keeps its value
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en ##1 $stable(dbg_addr) |-> $stable(dbg_data));
endmodule

// File: rtl/opnd_fwd.sv
module opnd_fwd #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 3
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] ex_dst,
  input  logic          ex_kill,
  input  logic [DW-1:0] ex_val,
  input  logic [AW-1:0] wr_dst,
  input  logic          wr_kill,
  input  logic [DW-1:0] wr_val,
  input  logic [DW-1:0] rf_val,
  output logic [DW-1:0] opnd
);
  logic hit_ex;
  logic hit_wr;

  always_comb begin
    hit_ex = (src == ex_dst) && !ex_kill;
    hit_wr = (src == wr_dst) && !wr_kill;
    if (hit_ex) begin
      opnd = ex_val;
    end else if (hit_wr) begin
      opnd = wr_val;
    end else begin
      opnd = rf_val;
    end
  end
endmodule

// File: rtl/alu_unit.sv
module alu_unit
  import pipe3_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  always_comb begin
    unique case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_XOR:  y = a ^ b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/pipe3_core.sv
module pipe3_core
  import pipe3_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = 8,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    in_op,
  input  logic [AW-1:0] in_src_a,
  input  logic [AW-1:0] in_src_b,
  input  logic [AW-1:0] in_dst,
  input  logic          in_stall,
  input  logic [AW-1:0] dbg_addr,
  output logic [DW-1:0] dbg_data
);
  // compute-stage state
  alu_op_e       op_ex_q,    op_ex_nxt;
  logic [AW-1:0] dst_ex_q,   dst_ex_nxt;
  logic          kill_ex_q,  kill_ex_nxt;
  logic [DW-1:0] opnd_q   [NUM_OPND];
  logic [DW-1:0] opnd_nxt [NUM_OPND];
  logic          opnd_en;
  // write-stage state
  logic [AW-1:0] dst_wr_q,   dst_wr_nxt;
  logic          kill_wr_q,  kill_wr_nxt;
  logic [DW-1:0] wb_q,       wb_nxt;
  logic          wb_en;

  logic [NUM_OPND-1:0][AW-1:0] src;
  logic [NUM_OPND-1:0][DW-1:0] rf_rd;
  logic [DW-1:0]               alu_y;
  logic                        rf_we;

  always_comb begin
    src[0] = in_src_a;
    src[1] = in_src_b;
  end

  rf_bank #(.DW(DW), .NREG(NREG), .NRD(NUM_OPND)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (rf_we),
    .wr_addr  (dst_wr_q),
    .wr_data  (wb_q),
    .rd_addr  (src),
    .rd_data  (rf_rd),
    .dbg_addr (dbg_addr),
    .dbg_data (dbg_data)
  );

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    opnd_fwd #(.DW(DW), .AW(AW)) u_fwd (
      .src     (src[g]),
      .ex_dst  (dst_ex_q),
      .ex_kill (kill_ex_q),
      .ex_val  (alu_y),
      .wr_dst  (dst_wr_q),
      .wr_kill (kill_wr_q),
      .wr_val  (wb_q),
      .rf_val  (rf_rd[g]),
      .opnd    (opnd_nxt[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        opnd_q[g] <= '0;
      end else if (opnd_en) begin
        opnd_q[g] <= opnd_nxt[g];
      end
    end

    // R4: a live compute-stage match supplies the ALU output
    p_fwd_alu_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_stall && src[g] == dst_ex_q && !kill_ex_q)
      |=> opnd_q[g] == $past(alu_y));

    // R5: a write-stage match alone supplies the write-back register
    p_fwd_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_stall && !(src[g] == dst_ex_q && !kill_ex_q)
       && src[g] == dst_wr_q && !kill_wr_q)
      |=> opnd_q[g] == $past(wb_q));

    // R6: with both stages matching, the younger result is taken
    p_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_stall && src[g] == dst_ex_q && !kill_ex_q
       && src[g] == dst_wr_q && !kill_wr_q)
      |=> opnd_q[g] != $past(wb_q) || $past(alu_y) == $past(wb_q));

    // R8: aborted in-flight instructions are bypassed in favour of the file
    p_rf_path_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_stall && !(src[g] == dst_ex_q && !kill_ex_q)
       && !(src[g] == dst_wr_q && !kill_wr_q))
      |=> opnd_q[g] == $past(rf_rd[g]));
  end

  alu_unit #(.DW(DW)) u_alu (
    .op (op_ex_q),
    .a  (opnd_q[0]),
    .b  (opnd_q[1]),
    .y  (alu_y)
  );

  // next-state
  always_comb begin
    opnd_en     = !in_stall;
    op_ex_nxt   = alu_op_e'(in_op);
    dst_ex_nxt  = in_dst;
    kill_ex_nxt = in_stall;
    wb_en       = !kill_ex_q;
    wb_nxt      = alu_y;
    dst_wr_nxt  = dst_ex_q;
    kill_wr_nxt = kill_ex_q;
    rf_we       = !kill_wr_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_ex_q   <= OP_ADD;
      dst_ex_q  <= '0;
      kill_ex_q <= 1'b1;
      dst_wr_q  <= '0;
      kill_wr_q <= 1'b1;
    end else begin
      op_ex_q   <= op_ex_nxt;
      dst_ex_q  <= dst_ex_nxt;
      kill_ex_q <= kill_ex_nxt;
      dst_wr_q  <= dst_wr_nxt;
      kill_wr_q <= kill_wr_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_q <= '0;
    end else if (wb_en) begin
      wb_q <= wb_nxt;
    end
  end

  // R7: a stalled instruction reaches the write stage with its flag still set
  p_kill_travels_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_stall |=> ##1 !rf_we);
endmodule

// File: tb/pipe3_core_tb.sv
module pipe3_core_tb;
  localparam int DW   = 16;
  localparam int NREG = 8;
  localparam int AW   = 3;
  localparam int NV   = 20;
  localparam int NR   = 400;
  localparam int NTOT = NV + NR;

  // {stall, op, src_a, src_b, dst}
  localparam logic [11:0] VEC [NV] = '{
    {1'b0, 2'd0, 3'd2, 3'd3, 3'd1},
    {1'b0, 2'd1, 3'd1, 3'd2, 3'd4},
    {1'b0, 2'd3, 3'd1, 3'd4, 3'd5},
    {1'b0, 2'd2, 3'd5, 3'd7, 3'd6},
    {1'b0, 2'd0, 3'd1, 3'd1, 3'd1},
    {1'b0, 2'd0, 3'd1, 3'd2, 3'd1},
    {1'b0, 2'd0, 3'd1, 3'd1, 3'd1},
    {1'b1, 2'd0, 3'd0, 3'd7, 3'd3},
    {1'b0, 2'd0, 3'd3, 3'd0, 3'd2},
    {1'b1, 2'd1, 3'd4, 3'd4, 3'd2},
    {1'b1, 2'd0, 3'd0, 3'd0, 3'd2},
    {1'b0, 2'd3, 3'd2, 3'd2, 3'd0},
    {1'b0, 2'd1, 3'd0, 3'd6, 3'd7},
    {1'b0, 2'd2, 3'd7, 3'd1, 3'd6},
    {1'b0, 2'd3, 3'd6, 3'd7, 3'd6},
    {1'b0, 2'd1, 3'd6, 3'd6, 3'd6},
    {1'b1, 2'd3, 3'd6, 3'd6, 3'd6},
    {1'b0, 2'd0, 3'd6, 3'd5, 3'd3},
    {1'b0, 2'd1, 3'd3, 3'd3, 3'd3},
    {1'b0, 2'd0, 3'd3, 3'd7, 3'd7}
  };

  logic          clk;
  logic          rst_n;
  logic [1:0]    in_op;
  logic [AW-1:0] in_src_a, in_src_b, in_dst, dbg_addr;
  logic          in_stall;
  logic [DW-1:0] dbg_data;

  int nchk;
  int nerr;

  logic [DW-1:0] ref_rf  [NREG];
  logic [AW-1:0] rec_dst [NTOT];
  logic [DW-1:0] rec_val [NTOT];
  string         rec_tag [NTOT];
  logic [AW-1:0] h1_dst, h2_dst;
  logic          h1_st, h2_st;

  pipe3_core #(.DW(DW), .NREG(NREG)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_op    (in_op),
    .in_src_a (in_src_a),
    .in_src_b (in_src_b),
    .in_dst   (in_dst),
    .in_stall (in_stall),
    .dbg_addr (dbg_addr),
    .dbg_data (dbg_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [DW-1:0] ref_alu(input logic [1:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b);
    case (op)
      2'd0:    return a + b;
      2'd1:    return a - b;
      2'd2:    return a & b;
      default: return a ^ b;
    endcase
  endfunction

  function automatic string classify(input logic st, input logic [AW-1:0] a, input logic [AW-1:0] b);
    string t;
    t = "R2 R3";
    if (st) return "R7";
    for (int s = 0; s < 2; s++) begin
      logic [AW-1:0] x;
      x = (s == 0) ? a : b;
      if (x == h1_dst && !h1_st && x == h2_dst && !h2_st) return "R6";
      if (x == h1_dst && !h1_st) t = "R4";
      else if (x == h2_dst && !h2_st && t != "R4") t = "R5";
      else if ((x == h1_dst && h1_st) || (x == h2_dst && h2_st))
        if (t == "R2 R3") t = "R8";
    end
    return t;
  endfunction

  task automatic issue(input int k, input logic [11:0] v);
    logic          st;
    logic [1:0]    op;
    logic [AW-1:0] a, b, d;
    {st, op, a, b, d} = v;
    in_stall = st; in_op = op; in_src_a = a; in_src_b = b; in_dst = d;
    rec_tag[k] = classify(st, a, b);
    if (!st) ref_rf[d] = ref_alu(op, ref_rf[a], ref_rf[b]);
    rec_dst[k] = d;
    rec_val[k] = ref_rf[d];
    h2_dst = h1_dst; h2_st = h1_st;
    h1_dst = d;      h1_st = st;
  endtask

  initial begin
    #(8 * 200000);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    nchk = 0; nerr = 0;
    rst_n = 1'b0; in_stall = 1'b1; in_op = '0;
    in_src_a = '0; in_src_b = '0; in_dst = '0; dbg_addr = '0;
    h1_dst = '0; h2_dst = '0; h1_st = 1'b1; h2_st = 1'b1;
    for (int i = 0; i < NREG; i++) ref_rf[i] = DW'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset contents
    for (int i = 0; i < NREG; i++) begin
      dbg_addr = AW'(i); #1;
      check("R1 reset value", dbg_data, DW'(i));
    end
    // R1: stalled traffic after release writes nothing
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      in_stall = 1'b1; in_dst = AW'(c); in_op = 2'd3;
    end
    @(negedge clk);
    for (int i = 0; i < NREG; i++) begin
      dbg_addr = AW'(i); #1;
      check("R1 no write after release", dbg_data, DW'(i));
    end
    // directed table then random traffic; result checked three cycles later
    for (int k = 0; k < NTOT + 3; k++) begin
      @(negedge clk);
      if (k < NV) begin
        issue(k, VEC[k]);
      end else if (k < NTOT) begin
        logic [11:0] rv;
        rv = {($urandom_range(3, 0) == 0) ? 1'b1 : 1'b0, 2'($urandom_range(3, 0)),
              3'($urandom_range(7, 0)), 3'($urandom_range(7, 0)), 3'($urandom_range(7, 0))};
        issue(k, rv);
      end else begin
        in_stall = 1'b1;
      end
      if (k >= 3) begin
        dbg_addr = rec_dst[k-3]; #1;
        check(rec_tag[k-3], dbg_data, rec_val[k-3]);
      end
    end
    // R9: same-cycle debug reads of the whole file
    @(negedge clk);
    for (int i = 0; i < NREG; i++) begin
      dbg_addr = AW'(i); #1;
      check("R9 final contents", dbg_data, ref_rf[i]);
    end
    // R1: asynchronous reset restores index values
    rst_n = 1'b0; #1;
    for (int i = 0; i < NREG; i++) begin
      dbg_addr = AW'(i); #1;
      check("R1 reset mid-run", dbg_data, DW'(i));
    end
    rst_n = 1'b1;
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule